// File: doc/BRIEF.md
# Serial PCM Highway Slot Port

This block connects a telephony line device to a time-division PCM highway. A frame sync pulse restarts a bit-clock counter, and the counter positions one transmit sample and one receive sample in each frame. The transmit sample goes out serially on the data-out pin while an output enable is asserted. The receive sample is shifted in from the data-in pin. Each direction has its own start count, given in clock cycles from the frame sync rather than as a slot number.

Because the start point is a raw cycle count, one mechanism covers several cases. Short and long frame syncs differ only by an offset of one. Slots that begin partway through an 8-bit boundary need no extra logic. Three mode inputs choose the sample width (8 or 16 bits), the clock edge on which the output driver lets go after the last bit, and a double-clock timing in which each bit spans two clock cycles. On the parallel side, a load strobe fills a transmit holding register. A one-cycle valid strobe marks each new received sample.

The port's clock is the highway bit clock itself. Outgoing data changes on the rising edge and incoming data is sampled on the falling edge. Clock generation and companding are done elsewhere, and the mode and start values arrive as plain inputs.

Top module: `pcm_slot_port`

## Requirements
- R1: The rising edge of `fsync` is sampled on a rising clock edge, and the next clock cycle is count 0. After that the count rises by one per cycle. It stops at 1023 instead of wrapping. Before the first sync, and while the count is stopped at 1023, no transfer starts in either direction.
- R2: The MSB of the transmit sample is driven on `dtx` during the cycle whose count equals `tx_start`. The remaining bits follow, MSB first. `dtx_oe` is high exactly over those bit cycles.
- R3: The first received bit is the `drx` value taken at the falling edge of the cycle whose count equals `rx_start`. Bits arrive MSB first. In the cycle after the last bit cycle, `rx_sample` holds the word and `rx_valid` is high for exactly one cycle.
- R4: With `cfg_wide`=1 a sample has 16 bits. With `cfg_wide`=0 it has 8 bits: `tx_sample[7:0]` is sent, its upper byte is ignored, and `rx_sample` carries the received byte in bits [7:0] with bits [15:8] zero.
- R5: With `cfg_dbl`=1 each bit lasts two clock cycles. On transmit, the bit is held for both cycles. On receive, the bit is taken at the falling edge of its first cycle.
- R6: With `cfg_early_rel`=1, `dtx_oe` falls at the falling edge inside the final cycle of the LSB. With `cfg_early_rel`=0 it stays high until the rising edge that ends that cycle.
- R7: `dtx` is 0 whenever `dtx_oe` is low.
- R8: A start count that the counter does not reach before the next frame sync produces no transfer. `dtx_oe` stays low and `rx_valid` never pulses for that direction.
- R9: While `fsync` stays high for several cycles (long sync), the count restarts only once. A start count of 0 places the slot in the first cycle after the sync edge.
- R10: `tx_load` stores `tx_sample` into a holding register at a rising edge. The holding register is copied into the transmit shifter when the transmit start count is reached, so a load during a transmission changes only the next frame's sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, rising edge restarts the count |
| drx | input | 1 | Serial receive data |
| cfg_wide | input | 1 | 1 selects 16-bit samples, 0 selects 8-bit samples |
| cfg_dbl | input | 1 | 1 selects two clock cycles per bit |
| cfg_early_rel | input | 1 | 1 releases the driver on the falling edge inside the LSB |
| tx_start | input | 10 | Count at which the transmit MSB starts |
| rx_start | input | 10 | Count at which the receive MSB starts |
| tx_sample | input | 16 | Parallel transmit word |
| tx_load | input | 1 | Stores tx_sample into the holding register |
| dtx | output | 1 | Serial transmit data |
| dtx_oe | output | 1 | Output enable for dtx |
| rx_sample | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new rx_sample |

## Verification
The main function is exercised with frames that combine every width and bit-timing pair. Each frame uses a different transmit start and receive start, with asymmetric data words, so that an off-by-one in start position, bit order or bit duration produces a wrong bit. A short-sync frame at count 1 is contrasted with a long-sync frame at count 0, which separates restart-on-edge from restart-on-level. A frame with both starts beyond the frame end, a long sync-free run that parks the counter, and a holding-register reload during an active slot test the cases where nothing, or only the old sample, may appear. The output enable is also checked after the falling edge of the last bit cycle, which tells the two release modes apart.

// File: rtl/pcm_slot_pkg.sv
`timescale 1ns/1ps
package pcm_slot_pkg;

    typedef struct packed {
        logic wide;
        logic dbl;
        logic early_rel;
    } pcm_mode_t;

    // Clock cycles occupied by one sample for the given mode
    function automatic int unsigned span_cycles(input pcm_mode_t m,
                                                input int unsigned narrow_w,
                                                input int unsigned wide_w);
        int unsigned bits;
        bits = m.wide ? wide_w : narrow_w;
        return m.dbl ? bits * 2 : bits;
    endfunction

endpackage

// File: rtl/pcm_frame_counter.sv
`timescale 1ns/1ps
module pcm_frame_counter #(
    parameter int CNT_W = 10
) (
    input  logic             pclk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             live_q,
    output logic             live_d
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             fs_prev;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_q, s_d;

    always_comb begin
        s_d         = s_q;
        s_d.fs_prev = fsync;
        if (fsync && !s_q.fs_prev) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != CNT_MAX) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.fs_prev <= 1'b0;
            s_q.cnt     <= CNT_MAX;
        end else begin
            s_q <= s_d;
        end
    end

    // The all-ones value is the parked state and never starts a slot
    assign cnt_q  = s_q.cnt;
    assign cnt_d  = s_d.cnt;
    assign live_q = (s_q.cnt != CNT_MAX);
    assign live_d = (s_d.cnt != CNT_MAX);

endmodule

// File: rtl/pcm_tx_shifter.sv
`timescale 1ns/1ps
module pcm_tx_shifter
    import pcm_slot_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 8
) (
    input  logic                pclk,
    input  logic                rst_n,
    input  pcm_mode_t           mode,
    input  logic                go,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic                tx_load,
    output logic                dtx,
    output logic                dtx_oe
);
    localparam int CYC_W = $clog2(2 * SAMPLE_W) + 1;
    localparam int PAD_W = SAMPLE_W - NARROW_W;

    typedef struct packed {
        logic [SAMPLE_W-1:0] hold;
        logic [SAMPLE_W-1:0] sh;
        logic [CYC_W-1:0]    k;
        logic                busy;
    } tx_state_t;

    tx_state_t        s_q, s_d;
    logic [CYC_W-1:0] total;
    logic             last;
    logic             cut_q;

    always_comb begin
        total = CYC_W'(span_cycles(mode, NARROW_W, SAMPLE_W));
        last  = s_q.busy && (s_q.k == total - 1'b1);
        s_d   = s_q;
        if (tx_load) begin
            s_d.hold = tx_sample;
        end
        if (go) begin
            s_d.sh   = mode.wide ? s_q.hold
                                 : {s_q.hold[NARROW_W-1:0], {PAD_W{1'b0}}};
            s_d.k    = '0;
            s_d.busy = 1'b1;
        end else if (s_q.busy) begin
            s_d.k = s_q.k + 1'b1;
            if (last) begin
                s_d.busy = 1'b0;
            end
            // In double-clock timing the bit advances after its second cycle
            if (!mode.dbl || s_q.k[0]) begin
                s_d.sh = {s_q.sh[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Falling-edge stage that cuts the driver half a cycle early
    always_ff @(negedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            cut_q <= 1'b0;
        end else begin
            cut_q <= last && mode.early_rel;
        end
    end

    assign dtx_oe = s_q.busy && !cut_q;
    assign dtx    = dtx_oe && s_q.sh[SAMPLE_W-1];

endmodule

// File: rtl/pcm_rx_shifter.sv
`timescale 1ns/1ps
module pcm_rx_shifter
    import pcm_slot_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 8
) (
    input  logic                pclk,
    input  logic                rst_n,
    input  pcm_mode_t           mode,
    input  logic                go,
    input  logic                drx,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);
    localparam int CYC_W = $clog2(2 * SAMPLE_W) + 1;

    typedef struct packed {
        logic [SAMPLE_W-1:0] sh;
        logic [SAMPLE_W-1:0] sample;
        logic [CYC_W-1:0]    k;
        logic                busy;
        logic                valid;
    } rx_state_t;

    rx_state_t           s_q, s_d;
    logic [CYC_W-1:0]    total;
    logic [SAMPLE_W-1:0] shift_in;
    logic [SAMPLE_W-1:0] sh_new;
    logic                drx_n_q;

    // Data pin taken mid-cycle on the falling edge
    always_ff @(negedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            drx_n_q <= 1'b0;
        end else begin
            drx_n_q <= drx;
        end
    end

    always_comb begin
        total    = CYC_W'(span_cycles(mode, NARROW_W, SAMPLE_W));
        shift_in = {s_q.sh[SAMPLE_W-2:0], drx_n_q};
        sh_new   = s_q.sh;
        s_d      = s_q;
        s_d.valid = 1'b0;
        if (go) begin
            s_d.sh   = shift_in;
            s_d.k    = CYC_W'(1);
            s_d.busy = 1'b1;
        end else if (s_q.busy) begin
            // Double-clock timing keeps only the first cycle of each bit
            if (!mode.dbl || !s_q.k[0]) begin
                sh_new = shift_in;
            end
            s_d.sh = sh_new;
            s_d.k  = s_q.k + 1'b1;
            if (s_q.k == total - 1'b1) begin
                s_d.busy   = 1'b0;
                s_d.valid  = 1'b1;
                s_d.sample = mode.wide ? sh_new
                                       : SAMPLE_W'(sh_new[NARROW_W-1:0]);
            end
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_sample = s_q.sample;
    assign rx_valid  = s_q.valid;

endmodule

// File: rtl/pcm_slot_port.sv
`timescale 1ns/1ps
module pcm_slot_port
    import pcm_slot_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 8
) (
    input  logic                pclk,
    input  logic                rst_n,
    input  logic                fsync,
    input  logic                drx,
    input  logic                cfg_wide,
    input  logic                cfg_dbl,
    input  logic                cfg_early_rel,
    input  logic [CNT_W-1:0]    tx_start,
    input  logic [CNT_W-1:0]    rx_start,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic                tx_load,
    output logic                dtx,
    output logic                dtx_oe,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);
    pcm_mode_t        mode;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             live_q;
    logic             live_d;
    logic             tx_go;
    logic             rx_go;

    assign mode = '{wide: cfg_wide, dbl: cfg_dbl, early_rel: cfg_early_rel};

    pcm_frame_counter #(.CNT_W(CNT_W)) u_cnt (
        .pclk   (pclk),
        .rst_n  (rst_n),
        .fsync  (fsync),
        .cnt_q  (cnt_q),
        .cnt_d  (cnt_d),
        .live_q (live_q),
        .live_d (live_d)
    );

    // Transmit compares the upcoming count so the MSB leaves at that count;
    // receive compares the present count and shifts at its closing edge.
    assign tx_go = live_d && (cnt_d == tx_start);
    assign rx_go = live_q && (cnt_q == rx_start);

    pcm_tx_shifter #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_tx (
        .pclk      (pclk),
        .rst_n     (rst_n),
        .mode      (mode),
        .go        (tx_go),
        .tx_sample (tx_sample),
        .tx_load   (tx_load),
        .dtx       (dtx),
        .dtx_oe    (dtx_oe)
    );

    pcm_rx_shifter #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_rx (
        .pclk      (pclk),
        .rst_n     (rst_n),
        .mode      (mode),
        .go        (rx_go),
        .drx       (drx),
        .rx_sample (rx_sample),
        .rx_valid  (rx_valid)
    );

endmodule

// File: rtl/pcm_slot_port_chk.sv
`timescale 1ns/1ps
module pcm_slot_port_chk #(
    parameter int CNT_W = 10
) (
    input logic             pclk,
    input logic             rst_n,
    input logic             fsync,
    input logic [CNT_W-1:0] cnt_q,
    input logic             dtx,
    input logic             dtx_oe,
    input logic             rx_valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R1
    frame_restart_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        (fsync && !$past(fsync)) |=> (cnt_q == '0));

    // R1
    count_step_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        (cnt_q != CNT_MAX && !(fsync && !$past(fsync))) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R1
    count_hold_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !(fsync && !$past(fsync))) |=> (cnt_q == CNT_MAX));

    // R7
    dtx_quiet_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        !dtx_oe |-> !dtx);

    // R3
    valid_single_pulse_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

bind pcm_slot_port pcm_slot_port_chk #(.CNT_W(CNT_W)) u_chk (
    .pclk     (pclk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .cnt_q    (cnt_q),
    .dtx      (dtx),
    .dtx_oe   (dtx_oe),
    .rx_valid (rx_valid)
);

// File: tb/tb_pcm_slot_port.sv
`timescale 1ns/1ps
module tb_pcm_slot_port;
    localparam int FRAME = 48;
    localparam int NVEC  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        drx = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_dbl = 1'b0;
    logic        cfg_early_rel = 1'b0;
    logic [9:0]  tx_start = '0;
    logic [9:0]  rx_start = '0;
    logic [15:0] tx_sample = '0;
    logic        tx_load = 1'b0;
    logic        dtx;
    logic        dtx_oe;
    logic [15:0] rx_sample;
    logic        rx_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pcm_slot_port dut (
        .pclk(clk), .rst_n(rst_n), .fsync(fsync), .drx(drx),
        .cfg_wide(cfg_wide), .cfg_dbl(cfg_dbl), .cfg_early_rel(cfg_early_rel),
        .tx_start(tx_start), .rx_start(rx_start),
        .tx_sample(tx_sample), .tx_load(tx_load),
        .dtx(dtx), .dtx_oe(dtx_oe), .rx_sample(rx_sample), .rx_valid(rx_valid)
    );

    // {wide, dbl, early, long sync, tx start, rx start, tx word, rx word}
    localparam logic [55:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 10'd1,  10'd1,  16'h00A5, 16'h003C},
        {1'b0, 1'b0, 1'b1, 1'b0, 10'd9,  10'd17, 16'hFF96, 16'h005A},
        {1'b1, 1'b0, 1'b0, 1'b0, 10'd3,  10'd20, 16'hBEEF, 16'h1234},
        {1'b0, 1'b1, 1'b1, 1'b0, 10'd2,  10'd5,  16'h0081, 16'h00E7},
        {1'b1, 1'b1, 1'b0, 1'b0, 10'd4,  10'd6,  16'hC0DE, 16'h8001},
        {1'b0, 1'b0, 1'b0, 1'b1, 10'd0,  10'd0,  16'h007E, 16'h0099},
        {1'b0, 1'b0, 1'b0, 1'b0, 10'd60, 10'd55, 16'h0055, 16'h00AA}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One frame: optional load, sync, then per-cycle drive and compare.
    task automatic run_frame(input bit wide, input bit dbl, input bit early, input bit longfs,
                             input int ts, input int rs,
                             input logic [15:0] txw, input logic [15:0] rxw,
                             input bit do_load, input int mid_c, input logic [15:0] mid_w,
                             input string req);
        int nb, per, tot;
        bit in_tx, exp_v;
        logic [15:0] exp_s;
        nb  = wide ? 16 : 8;
        per = dbl ? 2 : 1;
        tot = nb * per;
        exp_s = wide ? rxw : {8'h00, rxw[7:0]};
        cfg_wide = wide; cfg_dbl = dbl; cfg_early_rel = early;
        tx_start = 10'(ts); rx_start = 10'(rs);
        @(posedge clk); #1;
        if (do_load) begin tx_sample = txw; tx_load = 1'b1; end
        @(posedge clk); #1;
        tx_load = 1'b0;
        fsync = 1'b1;
        @(posedge clk); #1;
        for (int c = 0; c < FRAME; c++) begin
            if (!longfs || c >= 4) fsync = 1'b0;
            if (c == mid_c) begin tx_sample = mid_w; tx_load = 1'b1; end
            else tx_load = 1'b0;
            if (c >= rs && c < rs + tot) drx = rxw[nb - 1 - (c - rs) / per];
            else drx = 1'b1;
            #1;
            in_tx = (c >= ts) && (c < ts + tot);
            // R2 enable window
            check({31'd0, dtx_oe}, {31'd0, in_tx}, $sformatf("R2 %s oe c=%0d", req, c));
            if (in_tx)
                check({31'd0, dtx}, {31'd0, txw[nb - 1 - (c - ts) / per]},
                      $sformatf("R2 %s dtx c=%0d", req, c));
            else
                check({31'd0, dtx}, 32'd0, $sformatf("R7 %s idle dtx c=%0d", req, c));
            // R3 valid strobe and word
            exp_v = (c == rs + tot);
            check({31'd0, rx_valid}, {31'd0, exp_v}, $sformatf("R3 %s valid c=%0d", req, c));
            if (exp_v)
                check({16'd0, rx_sample}, {16'd0, exp_s}, $sformatf("R3 %s word", req));
            if (c == ts + tot - 1) begin
                #4;
                // R6 release edge
                check({31'd0, dtx_oe}, {31'd0, !early}, $sformatf("R6 %s oe after fall", req));
            end
            @(posedge clk); #1;
        end
        tx_load = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 R7 reset state
        check({31'd0, dtx_oe}, 32'd0, "R7 reset oe");
        check({31'd0, dtx}, 32'd0, "R7 reset dtx");
        check({31'd0, rx_valid}, 32'd0, "R1 reset valid");
        check({16'd0, rx_sample}, 32'd0, "R1 reset word");
        rst_n = 1'b1;
        // R1 no activity before the first sync
        tx_start = 10'd0; rx_start = 10'd0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #2;
            check({31'd0, dtx_oe | rx_valid}, 32'd0, "R1 idle before sync");
        end

        // Table: R4 widths, R5 double clock, R6 release, R8 unreachable, R9 long sync
        for (int i = 0; i < NVEC; i++) begin
            logic [55:0] v;
            string rq;
            v = VECS[i];
            if (v[52]) rq = "R9";
            else if (v[51:42] >= 10'(FRAME)) rq = "R8";
            else if (v[54]) rq = "R5";
            else rq = "R4";
            run_frame(v[55], v[54], v[53], v[52], int'(v[51:42]), int'(v[41:32]),
                      v[31:16], v[15:0], 1'b1, -1, 16'h0000,
                      $sformatf("%s vec%0d", rq, i));
        end

        // R10 reload during an active slot keeps the current word
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 2, 30, 16'h00A5, 16'h0011,
                  1'b1, 4, 16'h003C, "R10 reload mid slot");
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 2, 30, 16'h003C, 16'h0022,
                  1'b0, -1, 16'h0000, "R10 next frame word");

        // R1 counter parks at its maximum and never wraps back to a start
        tx_start = 10'd5; rx_start = 10'd5; fsync = 1'b0;
        for (int i = 0; i < 1100; i++) begin
            @(posedge clk); #2;
            check({31'd0, dtx_oe | rx_valid}, 32'd0, "R1 parked counter");
        end
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 1, 1, 16'h00C6, 16'h006B,
                  1'b1, -1, 16'h0000, "R1 resume after park");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule